// File: doc/BRIEF.md
# Register Rename Map Table

This block translates architectural register numbers into physical register tags for an out-of-order core. Integer, floating-point and condition-code registers each have their own map table and their own free list of physical tags. A fourth class, for miscellaneous registers, is never renamed. Each miscellaneous register keeps a fixed tag that equals its index.

A rename request names a class and an index. It is accepted on a valid/ready handshake. The response is combinational and comes in the same cycle as the request. It carries the freshly allocated tag and the mapping it displaces, so that commit can later release the old tag and a squash can restore it. Integer register 0 is the hardwired zero register: it is never remapped and costs no free-list entry.

The block also has three other ports:
- a combinational lookup port;
- a set-entry port, which lets a recovery path write a mapping directly;
- a free port, which hands a released tag back to its class's free list.

Top module: `rn_rename_map`

## Requirements
- R1: After reset, architectural register i of the integer, floating-point and condition-code classes maps to physical tag i. Each of these classes' free lists holds tags 32..63, in ascending order from its head.
- R2: An accepted rename of a renamed-class register (not the zero register) returns the head of that class's free list as the new tag and the current mapping as the previous tag. From the next cycle on, the map entry holds the new tag.
- R3: A rename of integer register 0 is always accepted. It returns tag 0 as both the new and the previous tag, takes nothing from the free list, and leaves the map unchanged.
- R4: Class codes on the 3-bit class fields are: 0 integer, 1 floating-point, 2 condition-code, 3 miscellaneous. Each renamed class has its own map and free list, and activity in one class leaves the others unchanged.
- R5: For a miscellaneous register with index i, lookup returns tag i. A rename returns i as both the new and the previous tag and allocates nothing.
- R6: A set-entry on a miscellaneous register, or on integer register 0, never changes a mapping. It raises set_err in the same cycle when the supplied tag differs from the fixed tag.
- R7: Class codes 4 to 7 raise ren_err, lk_err or set_err on the port that carries them. Such requests are accepted but change no mapping and no free list.
- R8: ren_ready is low only for a renamed-class, non-zero request whose class free list is empty.
- R9: A free request appends its tag to the tail of its class's free list, and later renames hand tags out in first-in first-out order.
- R10: A rename and a free of the same class in one cycle both take effect. No tag is lost or duplicated.
- R11: A set-entry on an integer (except register 0), floating-point or condition-code register writes the map entry, and the new value is visible from the next cycle. If a rename and a set-entry hit the same entry in the same cycle, the set-entry value is kept.
- R12: Lookup is combinational. It reflects every map write made at earlier clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | Rename request present |
| ren_ready | output | 1 | Rename request can be accepted this cycle |
| ren_cls | input | 3 | Rename register class |
| ren_idx | input | 5 | Rename architectural index |
| ren_new_tag | output | 6 | Newly assigned physical tag |
| ren_prev_tag | output | 6 | Displaced physical tag |
| ren_err | output | 1 | Rename with an unknown class |
| lk_cls | input | 3 | Lookup register class |
| lk_idx | input | 5 | Lookup architectural index |
| lk_tag | output | 6 | Current physical tag |
| lk_err | output | 1 | Lookup with an unknown class |
| set_valid | input | 1 | Set-entry request present |
| set_cls | input | 3 | Set-entry register class |
| set_idx | input | 5 | Set-entry architectural index |
| set_tag | input | 6 | Tag to write |
| set_err | output | 1 | Illegal set-entry |
| fr_valid | input | 1 | Free request present |
| fr_cls | input | 3 | Class whose free list receives the tag |
| fr_tag | input | 6 | Tag being released |

## Verification
Every response port is combinational. ren_ready, ren_new_tag, ren_prev_tag, all error flags and lk_tag are therefore due in the same cycle the request is driven. Map writes and free-list pushes and pops land at the next rising edge, so their effects show up one cycle after the request. The bench drives each request just after a falling edge and checks the combinational outputs 2 ns later. It then steps across one rising edge, and only after that does it look up the updated state or issue the follow-up rename that exposes the free-list order.

// File: rtl/rn_pkg.sv
package rn_pkg;

    localparam int ARCH_REGS = 32;
    localparam int PHYS_REGS = 64;
    localparam int CLS_W     = 3;
    localparam int RN_CLASSES = 3;   // renamed classes with map and free list

    typedef enum logic [CLS_W-1:0] {
        CLS_INT  = 3'd0,
        CLS_FP   = 3'd1,
        CLS_CC   = 3'd2,
        CLS_MISC = 3'd3
    } rclass_e;

    function automatic logic cls_known(input logic [CLS_W-1:0] c);
        return c <= CLS_MISC;
    endfunction

    function automatic logic cls_renamed(input logic [CLS_W-1:0] c);
        return c < CLS_MISC;
    endfunction

    function automatic logic is_zero_reg(input logic [CLS_W-1:0] c, input int unsigned idx);
        return (c == CLS_INT) && (idx == 0);
    endfunction

endpackage

// File: rtl/rn_free_list.sv
module rn_free_list #(
    parameter int DEPTH     = 64,
    parameter int TW        = 6,
    parameter int INIT_BASE = 32,
    parameter int INIT_CNT  = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pop,
    input  logic          push,
    input  logic [TW-1:0] push_tag,
    output logic [TW-1:0] head_tag,
    output logic          empty,
    output logic [$clog2(DEPTH+1)-1:0] cnt
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [TW-1:0] slots [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic          full, do_pop, do_push;

    assign empty    = (cnt == '0);
    assign full     = (cnt == CW'(DEPTH));
    assign head_tag = slots[rd_ptr];
    assign do_pop   = pop && !empty;
    assign do_push  = push && (!full || do_pop);

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++)
                slots[k] <= (k < INIT_CNT) ? TW'(INIT_BASE + k) : '0;
            rd_ptr <= '0;
            wr_ptr <= PW'(INIT_CNT % DEPTH);
            cnt    <= CW'(INIT_CNT);
        end else begin
            if (do_push) begin
                slots[wr_ptr] <= push_tag;
                wr_ptr        <= bump(wr_ptr);
            end
            if (do_pop)
                rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)
                cnt <= cnt + 1'b1;
            else if (do_pop && !do_push)
                cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/rn_map_bank.sv
module rn_map_bank #(
    parameter int N_ARCH = 32,
    parameter int TW     = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [$clog2(N_ARCH)-1:0] rd_a_idx,
    output logic [TW-1:0]             rd_a_tag,
    input  logic [$clog2(N_ARCH)-1:0] rd_b_idx,
    output logic [TW-1:0]             rd_b_tag,
    input  logic                      ren_we,
    input  logic [$clog2(N_ARCH)-1:0] ren_idx,
    input  logic [TW-1:0]             ren_tag,
    input  logic                      set_we,
    input  logic [$clog2(N_ARCH)-1:0] set_idx,
    input  logic [TW-1:0]             set_tag
);
    logic [TW-1:0] entries [N_ARCH];
    logic          ren_blocked;

    assign rd_a_tag    = entries[rd_a_idx];
    assign rd_b_tag    = entries[rd_b_idx];
    // a direct set to the same entry wins over the rename write
    assign ren_blocked = set_we && (set_idx == ren_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ARCH; i++)
                entries[i] <= TW'(i);
        end else begin
            if (ren_we && !ren_blocked)
                entries[ren_idx] <= ren_tag;
            if (set_we)
                entries[set_idx] <= set_tag;
        end
    end

endmodule

// File: rtl/rn_rename_map.sv
module rn_rename_map
    import rn_pkg::*;
#(
    parameter int N_ARCH = rn_pkg::ARCH_REGS,
    parameter int N_PHYS = rn_pkg::PHYS_REGS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ren_valid,
    output logic                      ren_ready,
    input  logic [2:0]                ren_cls,
    input  logic [$clog2(N_ARCH)-1:0] ren_idx,
    output logic [$clog2(N_PHYS)-1:0] ren_new_tag,
    output logic [$clog2(N_PHYS)-1:0] ren_prev_tag,
    output logic                      ren_err,
    input  logic [2:0]                lk_cls,
    input  logic [$clog2(N_ARCH)-1:0] lk_idx,
    output logic [$clog2(N_PHYS)-1:0] lk_tag,
    output logic                      lk_err,
    input  logic                      set_valid,
    input  logic [2:0]                set_cls,
    input  logic [$clog2(N_ARCH)-1:0] set_idx,
    input  logic [$clog2(N_PHYS)-1:0] set_tag,
    output logic                      set_err,
    input  logic                      fr_valid,
    input  logic [2:0]                fr_cls,
    input  logic [$clog2(N_PHYS)-1:0] fr_tag
);
    localparam int IW = $clog2(N_ARCH);
    localparam int TW = $clog2(N_PHYS);
    localparam int CW = $clog2(N_PHYS+1);
    localparam int NR = RN_CLASSES;
    localparam logic [TW-1:0] ZERO_TAG = '0;

    logic [TW-1:0]    head   [NR];
    logic [TW-1:0]    cur_rn [NR];
    logic [TW-1:0]    cur_lk [NR];
    logic [NR-1:0]    fl_empty;
    logic [NR*CW-1:0] fl_cnt_flat;

    logic ren_zero, set_zero, ren_fire;

    assign ren_zero = is_zero_reg(ren_cls, 32'(ren_idx));
    assign set_zero = is_zero_reg(set_cls, 32'(set_idx));
    assign ren_fire = ren_valid && ren_ready && cls_renamed(ren_cls) && !ren_zero;

    for (genvar c = 0; c < NR; c++) begin : g_cls
        logic          hit_ren, hit_set, hit_free;
        logic [CW-1:0] cnt_c;

        assign hit_ren  = ren_fire && (ren_cls == 3'(c));
        assign hit_set  = set_valid && (set_cls == 3'(c)) && !set_zero;
        assign hit_free = fr_valid && (fr_cls == 3'(c));
        assign fl_cnt_flat[c*CW +: CW] = cnt_c;

        rn_free_list #(
            .DEPTH(N_PHYS), .TW(TW),
            .INIT_BASE(N_ARCH), .INIT_CNT(N_PHYS - N_ARCH)
        ) u_fl (
            .clk(clk), .rst(rst),
            .pop(hit_ren), .push(hit_free), .push_tag(fr_tag),
            .head_tag(head[c]), .empty(fl_empty[c]), .cnt(cnt_c)
        );

        rn_map_bank #(.N_ARCH(N_ARCH), .TW(TW)) u_map (
            .clk(clk), .rst(rst),
            .rd_a_idx(ren_idx), .rd_a_tag(cur_rn[c]),
            .rd_b_idx(lk_idx),  .rd_b_tag(cur_lk[c]),
            .ren_we(hit_ren), .ren_idx(ren_idx), .ren_tag(head[c]),
            .set_we(hit_set), .set_idx(set_idx), .set_tag(set_tag)
        );
    end

    // rename response and handshake
    always_comb begin
        ren_ready    = 1'b1;
        ren_new_tag  = '0;
        ren_prev_tag = '0;
        ren_err      = ren_valid && !cls_known(ren_cls);
        if (ren_zero) begin
            ren_new_tag  = ZERO_TAG;
            ren_prev_tag = ZERO_TAG;
        end else if (cls_renamed(ren_cls)) begin
            ren_ready    = !fl_empty[ren_cls[1:0]];
            ren_new_tag  = head[ren_cls[1:0]];
            ren_prev_tag = cur_rn[ren_cls[1:0]];
        end else if (ren_cls == CLS_MISC) begin
            ren_new_tag  = TW'(ren_idx);
            ren_prev_tag = TW'(ren_idx);
        end
    end

    // lookup
    always_comb begin
        lk_tag = '0;
        lk_err = !cls_known(lk_cls);
        if (cls_renamed(lk_cls))
            lk_tag = cur_lk[lk_cls[1:0]];
        else if (lk_cls == CLS_MISC)
            lk_tag = TW'(lk_idx);
    end

    // set-entry legality
    always_comb begin
        set_err = 1'b0;
        if (set_valid) begin
            if (!cls_known(set_cls))
                set_err = 1'b1;
            else if (set_cls == CLS_MISC)
                set_err = (set_tag != TW'(set_idx));
            else if (set_zero)
                set_err = (set_tag != ZERO_TAG);
        end
    end

endmodule

// File: rtl/rn_rename_map_chk.sv
module rn_rename_map_chk #(
    parameter int IW = 5,
    parameter int TW = 6,
    parameter int CW = 7,
    parameter int NR = 3,
    parameter int N_PHYS = 64
) (
    input logic           clk,
    input logic           rst,
    input logic           ren_valid,
    input logic           ren_ready,
    input logic [2:0]     ren_cls,
    input logic [IW-1:0]  ren_idx,
    input logic [TW-1:0]  ren_new_tag,
    input logic [TW-1:0]  ren_prev_tag,
    input logic           ren_err,
    input logic           set_valid,
    input logic [2:0]     set_cls,
    input logic [IW-1:0]  set_idx,
    input logic [TW-1:0]  set_tag,
    input logic           set_err,
    input logic           fr_valid,
    input logic [2:0]     fr_cls,
    input logic [NR*CW-1:0] fl_cnt
);
    logic [CW-1:0] cnt_sel;
    logic          rn_zero, rn_plain;

    always_comb begin
        cnt_sel = '0;
        if (ren_cls < 3'd3)
            cnt_sel = fl_cnt[ren_cls[1:0]*CW +: CW];
    end
    assign rn_zero  = (ren_cls == 3'd0) && (ren_idx == '0);
    assign rn_plain = (ren_cls < 3'd3) && !rn_zero;

    assert_fresh_tag_R2: assert property (@(posedge clk) disable iff (rst)
        ren_valid && ren_ready && rn_plain |-> ren_new_tag != ren_prev_tag);

    assert_zero_fixed_R3: assert property (@(posedge clk) disable iff (rst)
        ren_valid && rn_zero |-> ren_ready && ren_new_tag == '0 && ren_prev_tag == '0);

    assert_zero_no_alloc_R3: assert property (@(posedge clk) disable iff (rst)
        ren_valid && rn_zero && !fr_valid |=> $stable(fl_cnt));

    assert_misc_fixed_R5: assert property (@(posedge clk) disable iff (rst)
        ren_valid && ren_cls == 3'd3 |-> ren_new_tag == TW'(ren_idx) && ren_prev_tag == TW'(ren_idx));

    assert_misc_set_R6: assert property (@(posedge clk) disable iff (rst)
        set_valid && set_cls == 3'd3 && set_tag != TW'(set_idx) |-> set_err);

    assert_unknown_flag_R7: assert property (@(posedge clk) disable iff (rst)
        ren_valid && ren_cls > 3'd3 |-> ren_err && ren_ready);

    assert_unknown_nostate_R7: assert property (@(posedge clk) disable iff (rst)
        ren_valid && ren_cls > 3'd3 && !fr_valid |=> $stable(fl_cnt));

    assert_stall_cause_R8: assert property (@(posedge clk) disable iff (rst)
        ren_valid && !ren_ready |-> rn_plain && cnt_sel == '0);

    assert_pair_balance_R10: assert property (@(posedge clk) disable iff (rst)
        ren_valid && ren_ready && rn_plain && fr_valid && fr_cls == ren_cls |=> $stable(fl_cnt));

    for (genvar c = 0; c < NR; c++) begin : g_ovf
        assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
            fl_cnt[c*CW +: CW] <= CW'(N_PHYS));
    end

endmodule

bind rn_rename_map rn_rename_map_chk #(
    .IW(IW), .TW(TW), .CW(CW), .NR(NR), .N_PHYS(N_PHYS)
) u_chk (
    .clk(clk), .rst(rst),
    .ren_valid(ren_valid), .ren_ready(ren_ready), .ren_cls(ren_cls), .ren_idx(ren_idx),
    .ren_new_tag(ren_new_tag), .ren_prev_tag(ren_prev_tag), .ren_err(ren_err),
    .set_valid(set_valid), .set_cls(set_cls), .set_idx(set_idx), .set_tag(set_tag),
    .set_err(set_err), .fr_valid(fr_valid), .fr_cls(fr_cls), .fl_cnt(fl_cnt_flat)
);

// File: tb/tb_rn_rename_map.sv
module tb_rn_rename_map;
    localparam time HALF = 10ns;   // 50 MHz

    logic       clk = 1'b0;
    logic       rst;
    logic       ren_valid = 0, set_valid = 0, fr_valid = 0;
    logic       ren_ready, ren_err, lk_err, set_err;
    logic [2:0] ren_cls = 0, lk_cls = 0, set_cls = 0, fr_cls = 0;
    logic [4:0] ren_idx = 0, lk_idx = 0, set_idx = 0;
    logic [5:0] ren_new_tag, ren_prev_tag, lk_tag, set_tag = 0, fr_tag = 0;

    int n_chk = 0, n_fail = 0;

    always #HALF clk = ~clk;

    rn_rename_map dut (
        .clk(clk), .rst(rst),
        .ren_valid(ren_valid), .ren_ready(ren_ready), .ren_cls(ren_cls), .ren_idx(ren_idx),
        .ren_new_tag(ren_new_tag), .ren_prev_tag(ren_prev_tag), .ren_err(ren_err),
        .lk_cls(lk_cls), .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_err(lk_err),
        .set_valid(set_valid), .set_cls(set_cls), .set_idx(set_idx), .set_tag(set_tag),
        .set_err(set_err), .fr_valid(fr_valid), .fr_cls(fr_cls), .fr_tag(fr_tag)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive a rename after a falling edge, check the same-cycle response, cross one rising edge
    task automatic do_ren(input logic [2:0] c, input logic [4:0] i, input bit rdy,
                          input int exp_new, input int exp_prev, input string req);
        ren_valid = 1; ren_cls = c; ren_idx = i;
        #2;
        chk({req, " ready"}, int'(ren_ready), int'(rdy));
        if (rdy) begin
            chk({req, " new"}, int'(ren_new_tag), exp_new);
            chk({req, " prev"}, int'(ren_prev_tag), exp_prev);
        end
        @(negedge clk);
        ren_valid = 0;
    endtask

    task automatic look(input logic [2:0] c, input logic [4:0] i, input int exp, input string req);
        lk_cls = c; lk_idx = i;
        #2;
        chk({req, " lookup"}, int'(lk_tag), exp);
    endtask

    task automatic do_free(input logic [2:0] c, input logic [5:0] t);
        fr_valid = 1; fr_cls = c; fr_tag = t;
        @(negedge clk);
        fr_valid = 0;
    endtask

    task automatic t_reset();
        look(3'd0, 5'd0, 0, "R1");
        look(3'd0, 5'd17, 17, "R1");
        look(3'd1, 5'd31, 31, "R1");
        look(3'd2, 5'd5, 5, "R1");
        chk("R1 lk_err", int'(lk_err), 0);
    endtask

    task automatic t_basic();
        do_ren(3'd0, 5'd3, 1, 32, 3, "R2");
        look(3'd0, 5'd3, 32, "R12");
        do_ren(3'd0, 5'd3, 1, 33, 32, "R2");
        look(3'd1, 5'd3, 3, "R4");
        do_ren(3'd1, 5'd3, 1, 32, 3, "R4 fp list");
    endtask

    task automatic t_zero();
        do_ren(3'd0, 5'd0, 1, 0, 0, "R3");
        look(3'd0, 5'd0, 0, "R3");
        do_ren(3'd0, 5'd4, 1, 34, 4, "R3 no alloc");
    endtask

    task automatic t_misc();
        look(3'd3, 5'd9, 9, "R5");
        do_ren(3'd3, 5'd9, 1, 9, 9, "R5");
        do_ren(3'd0, 5'd5, 1, 35, 5, "R5 no alloc");
        set_valid = 1; set_cls = 3'd3; set_idx = 5'd9; set_tag = 6'd9;
        #2; chk("R6 legal misc set", int'(set_err), 0);
        @(negedge clk);
        set_tag = 6'd12;
        #2; chk("R6 bad misc set", int'(set_err), 1);
        @(negedge clk);
        set_cls = 3'd0; set_idx = 5'd0; set_tag = 6'd7;
        #2; chk("R6 bad zero set", int'(set_err), 1);
        @(negedge clk);
        set_valid = 0;
        look(3'd3, 5'd9, 9, "R6");
        look(3'd0, 5'd0, 0, "R6");
    endtask

    task automatic t_unknown();
        ren_valid = 1; ren_cls = 3'd5; ren_idx = 5'd2;
        lk_cls = 3'd6; lk_idx = 5'd2;
        set_valid = 1; set_cls = 3'd7; set_idx = 5'd2; set_tag = 6'd50;
        #2;
        chk("R7 ren_err", int'(ren_err), 1);
        chk("R7 lk_err", int'(lk_err), 1);
        chk("R7 set_err", int'(set_err), 1);
        @(negedge clk);
        ren_valid = 0; set_valid = 0;
        look(3'd0, 5'd2, 2, "R7");
        look(3'd2, 5'd2, 2, "R7");
        do_ren(3'd0, 5'd6, 1, 36, 6, "R7 no pop");
    endtask

    task automatic t_set();
        set_valid = 1; set_cls = 3'd0; set_idx = 5'd10; set_tag = 6'd50;
        @(negedge clk);
        set_valid = 0;
        look(3'd0, 5'd10, 50, "R11");
        set_valid = 1; set_idx = 5'd11; set_tag = 6'd44;
        do_ren(3'd0, 5'd11, 1, 37, 11, "R11 collide");
        set_valid = 0;
        look(3'd0, 5'd11, 44, "R11 set wins");
        do_ren(3'd0, 5'd12, 1, 38, 12, "R11 pop kept");
    endtask

    task automatic t_drain();
        for (int k = 0; k < 32; k++)
            do_ren(3'd2, 5'(k), 1, 32 + k, k, "R2 cc drain");
        do_ren(3'd2, 5'd1, 0, 0, 0, "R8 empty");
        do_ren(3'd1, 5'd1, 1, 33, 1, "R8 other class");
        do_free(3'd2, 6'd1);
        do_ren(3'd2, 5'd2, 1, 1, 34, "R9");
        do_free(3'd2, 6'd2);
        do_free(3'd2, 6'd3);
        fr_valid = 1; fr_cls = 3'd2; fr_tag = 6'd4;
        do_ren(3'd2, 5'd5, 1, 2, 37, "R10 pair");
        fr_valid = 0;
        do_ren(3'd2, 5'd6, 1, 3, 38, "R10");
        do_ren(3'd2, 5'd7, 1, 4, 39, "R10 freed tag kept");
        do_ren(3'd2, 5'd8, 0, 0, 0, "R8 empty again");
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(HALF * 2 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_basic();
        t_zero();
        t_misc();
        t_unknown();
        t_set();
        t_drain();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule